// File: doc/BRIEF.md
# Multi-Cycle Execute In-Order Pipeline

This block is a small in-order integer pipeline with four stages: fetch, decode, execute and writeback. It runs a program held in a local instruction memory over a register file of sixteen-bit words. Each instruction has one destination and two sources. The instruction set covers add, subtract, multiply, divide and a store that drives a register value out on a write port. Execute is one shared unit that is not pipelined. It holds an instruction for one cycle or three, depending on the opcode. While it is busy, decode and fetch wait in place.

A result leaves execute on a bypass path into decode. A consumer therefore picks up its operand in the last cycle of its producer and enters execute on the very next cycle. It does not wait for writeback. A second bypass covers the instruction that is in writeback while its consumer decodes.

The program and the initial register values are loaded through one preload port while the pipeline is idle. A start pulse then sets the program running. A cycle counter reads 1 during the first fetch. It stops, and a done flag rises, once the last instruction has left writeback.

Top module: `mcx_pipe_top`

## Requirements
- R1: Every instruction passes through fetch, decode, execute and writeback in that order. Fetch, decode and writeback take one cycle each, so a single one-cycle instruction finishes writeback in cycle 4.
- R2: Execute holds MUL (opcode 2) and DIV (opcode 3) for three cycles and holds every other opcode for one cycle. With no stall other than execute occupancy, a program finishes in 3 plus the sum of its execute latencies.
- R3: Only one instruction is in execute at a time. While it is there, decode and fetch keep their contents. An independent instruction behind a three-cycle operation still waits for execute to free up.
- R4: A result computed in execute is bypassed to decode in the producer's last execute cycle, and the dependent instruction enters execute on the next cycle. The chain ADD, MUL, SUB, DIV, STORE, each using the previous result, completes in cycle 12.
- R5: A register being written in writeback during the same cycle that a later instruction decodes it is delivered with its new value.
- R6: ADD and SUB (opcodes 0 and 1) wrap modulo 2^16. MUL keeps the low 16 bits of the product. DIV is unsigned and returns 0xFFFF when the divisor is zero.
- R7: STORE (opcode 4) puts the value of its source register (bits 9:7) on `st_data` and the 7-bit address in bits 6:0 on `st_addr`, with `st_we` high for one cycle during the store's writeback cycle.
- R8: The instruction word is opcode [15:13], destination [12:10], source A [9:7], source B [6:4]. Opcodes 5 to 7 take one execute cycle and write no register.
- R9: `cycle_cnt` is 1 during the first fetch after `start` and counts up once per cycle. When the last instruction leaves writeback, `done` rises and `cycle_cnt` stays frozen until the next `start`.
- R10: After reset, `done` is 0, `cycle_cnt` is 0 and `st_we` is 0.
- R11: While the pipeline is idle, `pre_we` writes `pre_data` into register `pre_addr[2:0]` when `pre_rf` is 1, or into instruction word `pre_addr` when `pre_rf` is 0. While a program runs, `pre_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; honoured only while idle |
| prog_len | input | 5 | Number of instructions to run from word 0 |
| pre_we | input | 1 | Preload write strobe |
| pre_rf | input | 1 | Preload target: 1 register file, 0 instruction memory |
| pre_addr | input | 4 | Preload address |
| pre_data | input | 16 | Preload data |
| st_we | output | 1 | Store strobe |
| st_addr | output | 7 | Store address |
| st_data | output | 16 | Store data |
| done | output | 1 | Program complete |
| cycle_cnt | output | 16 | Cycle counter, frozen at completion |

## Verification
The bench builds the block with its default parameters: 16-bit words, eight registers, a 16-word program memory, and execute latencies of one and three cycles. With 16-bit words, a multiply overflow and the all-ones divide-by-zero result can be reached with small operands. The 16-word memory holds every program the bench runs, including the dependent five-instruction chain. The one/three latency pair means each store's arrival cycle can be predicted as 3 plus the running sum of latencies. Checking that arrival cycle catches a missing stall, an extra stall and a missing bypass.

// File: rtl/mcx_pkg.sv
// Package: opcode values and small decode helpers shared by the pipeline.
// Assumes a 3-bit opcode at the top of each instruction word.
package mcx_pkg;
    localparam logic [2:0] OP_ADD   = 3'd0;
    localparam logic [2:0] OP_SUB   = 3'd1;
    localparam logic [2:0] OP_MUL   = 3'd2;
    localparam logic [2:0] OP_DIV   = 3'd3;
    localparam logic [2:0] OP_STORE = 3'd4;

    // True for opcodes that hold execute for the long latency
    function automatic logic op_is_long(input logic [2:0] op);
        return (op == OP_MUL) || (op == OP_DIV);
    endfunction

    // True for opcodes that write a destination register
    function automatic logic op_writes(input logic [2:0] op);
        return (op[2] == 1'b0);
    endfunction

    // True for opcodes that read source B
    function automatic logic op_uses_b(input logic [2:0] op);
        return (op[2] == 1'b0);
    endfunction
endpackage

// File: rtl/mcx_fetch.sv
// Fetch stage: instruction memory, program counter and the decode-stage
// instruction register. Assumes start only arrives while the pipeline is
// empty; holds its contents whenever decode cannot advance.
module mcx_fetch #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int IAW  = $clog2(DEPTH),
    localparam int PCW  = IAW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_go,
    input  logic           running,
    input  logic [PCW-1:0] prog_len,
    input  logic           imem_we,
    input  logic [IAW-1:0] imem_waddr,
    input  logic [DW-1:0]  imem_wdata,
    input  logic           id_adv,
    output logic           id_valid,
    output logic [DW-1:0]  id_ins,
    output logic           id_last
);
    logic [DW-1:0]  mem [DEPTH];
    logic [PCW-1:0] pc;
    logic           fetch_act;
    logic           if_adv;

    // Fetch is active while words remain; it advances only if decode frees up
    always_comb begin
        fetch_act = running && (pc < prog_len);
        if_adv    = fetch_act && (!id_valid || id_adv);
    end

    // Instruction storage written by the preload port
    always_ff @(posedge clk) begin
        if (imem_we) begin
            mem[imem_waddr] <= imem_wdata;
        end
    end

    // Program counter and decode register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            id_valid <= 1'b0;
            id_ins   <= '0;
            id_last  <= 1'b0;
        end else if (start_go) begin
            pc       <= '0;
            id_valid <= 1'b0;
        end else if (if_adv) begin
            id_valid <= 1'b1;
            id_ins   <= mem[pc[IAW-1:0]];
            id_last  <= (pc == prog_len - PCW'(1));
            pc       <= pc + PCW'(1);
        end else if (id_adv) begin
            id_valid <= 1'b0;
        end
    end

    // R3
    hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && id_valid && !id_adv) |=> ($stable(pc) && $stable(id_ins)));
endmodule

// File: rtl/mcx_regfile.sv
// Register file: NREG words with one writeback port, one preload port and
// two read ports. A read of the register being written in the same cycle
// returns the new value. Assumes preload and writeback never coincide.
module mcx_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic          pre_we,
    input  logic [RW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    output logic [DW-1:0] rda,
    output logic [DW-1:0] rdb
);
    logic [DW-1:0] regs [NREG];

    // Storage update: writeback has priority over preload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (wb_we) begin
            regs[wb_addr] <= wb_data;
        end else if (pre_we) begin
            regs[pre_addr] <= pre_data;
        end
    end

    // Read ports with write-through from writeback
    always_comb begin
        rda = (wb_we && (wb_addr == ra)) ? wb_data : regs[ra];
        rdb = (wb_we && (wb_addr == rb)) ? wb_data : regs[rb];
    end

    // R5
    wb_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |=> (regs[$past(wb_addr)] == $past(wb_data)));
endmodule

// File: rtl/mcx_decode.sv
// Decode stage: splits the instruction into fields, selects each operand
// from the execute bypass or the register file, and decides whether the
// instruction may move into execute. Assumes the execute result is valid
// only in the cycle its done flag is high.
module mcx_decode #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG),
    localparam int SAW = DW - 3 - 2 * RW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           id_valid,
    input  logic [DW-1:0]  id_ins,
    input  logic [DW-1:0]  rf_a,
    input  logic [DW-1:0]  rf_b,
    input  logic           ex_valid,
    input  logic           ex_done,
    input  logic           ex_wr,
    input  logic [RW-1:0]  ex_rd,
    input  logic [DW-1:0]  ex_result,
    output logic [RW-1:0]  src_a,
    output logic [RW-1:0]  src_b,
    output logic [2:0]     d_op,
    output logic [RW-1:0]  d_rd,
    output logic [DW-1:0]  d_a,
    output logic [DW-1:0]  d_b,
    output logic [SAW-1:0] d_saddr,
    output logic           id_adv
);
    import mcx_pkg::*;

    logic hit_a;
    logic hit_b;
    logic raw_wait;

    // Field extraction from the fixed instruction layout
    always_comb begin
        d_op    = id_ins[DW-1 -: 3];
        d_rd    = id_ins[DW-4 -: RW];
        src_a   = id_ins[DW-4-RW -: RW];
        src_b   = id_ins[DW-4-2*RW -: RW];
        d_saddr = id_ins[SAW-1:0];
    end

    // Operand select: the execute bypass wins over the register file
    always_comb begin
        hit_a = ex_valid && ex_wr && (ex_rd == src_a);
        hit_b = ex_valid && ex_wr && (ex_rd == src_b);
        d_a   = hit_a ? ex_result : rf_a;
        d_b   = hit_b ? ex_result : rf_b;
    end

    // Advance and hazard detection
    always_comb begin
        id_adv   = id_valid && (!ex_valid || ex_done);
        raw_wait = id_valid && !ex_done && (hit_a || (op_uses_b(d_op) && hit_b));
    end

    // R4
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_wait |=> (id_valid && $stable(id_ins)));
endmodule

// File: rtl/mcx_execute.sv
// Execute stage: a single non-pipelined unit that holds one instruction for
// a short or long latency chosen by opcode, and presents the result in
// its final cycle. Assumes decode loads it only when it is free or finishing.
module mcx_execute #(
    parameter int DW        = 16,
    parameter int NREG      = 8,
    parameter int LAT_SHORT = 1,
    parameter int LAT_LONG  = 3,
    localparam int RW       = $clog2(NREG),
    localparam int SAW      = DW - 3 - 2 * RW,
    localparam int CW       = $clog2(LAT_LONG + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           id_adv,
    input  logic [2:0]     d_op,
    input  logic [RW-1:0]  d_rd,
    input  logic [DW-1:0]  d_a,
    input  logic [DW-1:0]  d_b,
    input  logic [SAW-1:0] d_saddr,
    input  logic           d_last,
    output logic           ex_valid,
    output logic           ex_done,
    output logic           ex_wr,
    output logic [RW-1:0]  ex_rd,
    output logic [DW-1:0]  ex_result,
    output logic           ex_store,
    output logic [SAW-1:0] ex_saddr,
    output logic [DW-1:0]  ex_sdata,
    output logic           ex_last
);
    import mcx_pkg::*;

    logic [2:0]      ex_op;
    logic [DW-1:0]   ex_a;
    logic [DW-1:0]   ex_b;
    logic [CW-1:0]   ex_cnt;
    logic [2*DW-1:0] prod;

    // Occupancy register and latency countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid <= 1'b0;
            ex_op    <= '0;
            ex_rd    <= '0;
            ex_a     <= '0;
            ex_b     <= '0;
            ex_saddr <= '0;
            ex_last  <= 1'b0;
            ex_cnt   <= '0;
        end else if (!ex_valid || ex_done) begin
            if (id_adv) begin
                ex_valid <= 1'b1;
                ex_op    <= d_op;
                ex_rd    <= d_rd;
                ex_a     <= d_a;
                ex_b     <= d_b;
                ex_saddr <= d_saddr;
                ex_last  <= d_last;
                ex_cnt   <= op_is_long(d_op) ? CW'(LAT_LONG - 1) : CW'(LAT_SHORT - 1);
            end else begin
                ex_valid <= 1'b0;
            end
        end else begin
            ex_cnt <= ex_cnt - CW'(1);
        end
    end

    // Completion and control outputs
    always_comb begin
        ex_done  = ex_valid && (ex_cnt == '0);
        ex_wr    = ex_valid && op_writes(ex_op);
        ex_store = ex_valid && (ex_op == OP_STORE);
        ex_sdata = ex_a;
    end

    // Arithmetic: wrap on add/sub, low half of product, saturating divide-by-zero
    always_comb begin
        prod = {{DW{1'b0}}, ex_a} * {{DW{1'b0}}, ex_b};
        case (ex_op)
            OP_ADD:  ex_result = ex_a + ex_b;
            OP_SUB:  ex_result = ex_a - ex_b;
            OP_MUL:  ex_result = prod[DW-1:0];
            OP_DIV:  ex_result = (ex_b == '0) ? {DW{1'b1}} : (ex_a / ex_b);
            default: ex_result = ex_a;
        endcase
    end

    // R3
    ex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_done) |=> (ex_valid && $stable(ex_op) && $stable(ex_a) && $stable(ex_b)));

    // R2
    long_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((LAT_LONG > 1) && id_adv && op_is_long(d_op)) |=> !ex_done);

    // R2
    short_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((LAT_SHORT == 1) && id_adv && !op_is_long(d_op)) |=> ex_done);
endmodule

// File: rtl/mcx_pipe_top.sv
// Top level: ties fetch, decode, execute and the register file together,
// holds the writeback register, the store output register, the run
// control, the done flag and the cycle counter. Assumes the instruction
// word is as wide as the data word and pre_addr covers a register index.
module mcx_pipe_top #(
    parameter int DW        = 16,
    parameter int NREG      = 8,
    parameter int DEPTH     = 16,
    parameter int LAT_SHORT = 1,
    parameter int LAT_LONG  = 3,
    parameter int CNTW      = 16,
    localparam int RW       = $clog2(NREG),
    localparam int IAW      = $clog2(DEPTH),
    localparam int PCW      = IAW + 1,
    localparam int SAW      = DW - 3 - 2 * RW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PCW-1:0]  prog_len,
    input  logic            pre_we,
    input  logic            pre_rf,
    input  logic [IAW-1:0]  pre_addr,
    input  logic [DW-1:0]   pre_data,
    output logic            st_we,
    output logic [SAW-1:0]  st_addr,
    output logic [DW-1:0]   st_data,
    output logic            done,
    output logic [CNTW-1:0] cycle_cnt
);
    logic            running;
    logic            start_go;
    logic            id_valid;
    logic [DW-1:0]   id_ins;
    logic            id_last;
    logic            id_adv;
    logic [RW-1:0]   src_a;
    logic [RW-1:0]   src_b;
    logic [DW-1:0]   rf_a;
    logic [DW-1:0]   rf_b;
    logic [2:0]      d_op;
    logic [RW-1:0]   d_rd;
    logic [DW-1:0]   d_a;
    logic [DW-1:0]   d_b;
    logic [SAW-1:0]  d_saddr;
    logic            ex_valid;
    logic            ex_done;
    logic            ex_wr;
    logic [RW-1:0]   ex_rd;
    logic [DW-1:0]   ex_result;
    logic            ex_store;
    logic [SAW-1:0]  ex_saddr;
    logic [DW-1:0]   ex_sdata;
    logic            ex_last;
    logic            wb_valid;
    logic            wb_wr;
    logic [RW-1:0]   wb_rd;
    logic [DW-1:0]   wb_data;
    logic            wb_last;
    logic            pre_ok;

    // Start and preload are honoured only while idle
    always_comb begin
        start_go = start && !running;
        pre_ok   = pre_we && !running;
    end

    mcx_fetch #(.DW(DW), .DEPTH(DEPTH)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_go   (start_go),
        .running    (running),
        .prog_len   (prog_len),
        .imem_we    (pre_ok && !pre_rf),
        .imem_waddr (pre_addr),
        .imem_wdata (pre_data),
        .id_adv     (id_adv),
        .id_valid   (id_valid),
        .id_ins     (id_ins),
        .id_last    (id_last)
    );

    mcx_regfile #(.DW(DW), .NREG(NREG)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_we    (wb_valid && wb_wr),
        .wb_addr  (wb_rd),
        .wb_data  (wb_data),
        .pre_we   (pre_ok && pre_rf),
        .pre_addr (pre_addr[RW-1:0]),
        .pre_data (pre_data),
        .ra       (src_a),
        .rb       (src_b),
        .rda      (rf_a),
        .rdb      (rf_b)
    );

    mcx_decode #(.DW(DW), .NREG(NREG)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_valid  (id_valid),
        .id_ins    (id_ins),
        .rf_a      (rf_a),
        .rf_b      (rf_b),
        .ex_valid  (ex_valid),
        .ex_done   (ex_done),
        .ex_wr     (ex_wr),
        .ex_rd     (ex_rd),
        .ex_result (ex_result),
        .src_a     (src_a),
        .src_b     (src_b),
        .d_op      (d_op),
        .d_rd      (d_rd),
        .d_a       (d_a),
        .d_b       (d_b),
        .d_saddr   (d_saddr),
        .id_adv    (id_adv)
    );

    mcx_execute #(
        .DW(DW), .NREG(NREG), .LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG)
    ) u_execute (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_adv    (id_adv),
        .d_op      (d_op),
        .d_rd      (d_rd),
        .d_a       (d_a),
        .d_b       (d_b),
        .d_saddr   (d_saddr),
        .d_last    (id_last),
        .ex_valid  (ex_valid),
        .ex_done   (ex_done),
        .ex_wr     (ex_wr),
        .ex_rd     (ex_rd),
        .ex_result (ex_result),
        .ex_store  (ex_store),
        .ex_saddr  (ex_saddr),
        .ex_sdata  (ex_sdata),
        .ex_last   (ex_last)
    );

    // Writeback register and store output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_wr    <= 1'b0;
            wb_rd    <= '0;
            wb_data  <= '0;
            wb_last  <= 1'b0;
            st_we    <= 1'b0;
            st_addr  <= '0;
            st_data  <= '0;
        end else begin
            wb_valid <= ex_done;
            wb_wr    <= ex_done && ex_wr;
            wb_rd    <= ex_rd;
            wb_data  <= ex_result;
            wb_last  <= ex_done && ex_last;
            st_we    <= ex_done && ex_store;
            st_addr  <= ex_saddr;
            st_data  <= ex_sdata;
        end
    end

    // Run control, done flag and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            done      <= 1'b0;
            cycle_cnt <= '0;
        end else if (start_go) begin
            running   <= (prog_len != '0);
            done      <= (prog_len == '0);
            cycle_cnt <= (prog_len == '0) ? '0 : CNTW'(1);
        end else if (running) begin
            if (wb_valid && wb_last) begin
                running <= 1'b0;
                done    <= 1'b1;
            end else begin
                cycle_cnt <= cycle_cnt + CNTW'(1);
            end
        end
    end

    // R9
    done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(cycle_cnt)));

    // R7
    store_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> $past(ex_done && ex_store));

    // R1
    wb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(ex_valid));
endmodule

// File: tb/mcx_pipe_top_bench.sv
// Scoreboard bench: program-building tasks push expected stores (address,
// data, arrival cycle) into a queue; a monitor pops and compares each one.
module mcx_pipe_top_bench;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  prog_len = '0;
    logic        pre_we = 1'b0;
    logic        pre_rf = 1'b0;
    logic [3:0]  pre_addr = '0;
    logic [15:0] pre_data = '0;
    logic        st_we;
    logic [6:0]  st_addr;
    logic [15:0] st_data;
    logic        done;
    logic [15:0] cycle_cnt;

    typedef struct packed {
        logic [6:0]  addr;
        logic [15:0] data;
        logic [15:0] cyc;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails = 0;
    int   prog_idx = 0;
    int   lat_acc = 0;
    int   wd = 0;

    mcx_pipe_top u_mcx_pipe_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .prog_len  (prog_len),
        .pre_we    (pre_we),
        .pre_rf    (pre_rf),
        .pre_addr  (pre_addr),
        .pre_data  (pre_data),
        .st_we     (st_we),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .done      (done),
        .cycle_cnt (cycle_cnt)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: every store strobe is compared against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && st_we) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R7", "unexpected store", int'(st_addr), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(st_addr == e.addr, "R7", "store address", int'(st_addr), int'(e.addr));
                chk(st_data == e.data, "R6", "store data", int'(st_data), int'(e.data));
                chk(cycle_cnt == e.cyc, "R3", "store arrival cycle", int'(cycle_cnt), int'(e.cyc));
            end
        end
    end

    // Watchdog
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", wd, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Preload one word; called at a falling edge
    task automatic wr_pre(input bit rf, input int addr, input logic [15:0] d);
        pre_we   = 1'b1;
        pre_rf   = rf;
        pre_addr = 4'(addr);
        pre_data = d;
        @(negedge clk);
        pre_we   = 1'b0;
    endtask

    task automatic new_prog();
        prog_idx = 0;
        lat_acc  = 0;
    endtask

    task automatic put_op(input logic [2:0] op, input logic [2:0] rd,
                          input logic [2:0] ra, input logic [2:0] rb);
        wr_pre(1'b0, prog_idx, {op, rd, ra, rb, 4'b0000});
        prog_idx++;
        lat_acc += (op == 3'd2 || op == 3'd3) ? 3 : 1;
    endtask

    task automatic put_st(input logic [2:0] ra, input logic [6:0] addr,
                          input logic [15:0] expd);
        exp_t e;
        wr_pre(1'b0, prog_idx, {3'd4, 3'd0, ra, addr});
        prog_idx++;
        lat_acc += 1;
        e.addr = addr;
        e.data = expd;
        e.cyc  = 16'(3 + lat_acc);
        sbq.push_back(e);
    endtask

    // Start the loaded program, optionally poke a register mid-run, then check
    task automatic run_prog(input string req, input bit poke);
        int w;
        int frozen;
        prog_len = 5'(prog_idx);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        if (poke) begin
            wr_pre(1'b1, 7, 16'hDEAD);
        end
        w = 0;
        while (!done && w < 500) begin
            @(negedge clk);
            w++;
        end
        chk(done == 1'b1, "R9", "done after program", int'(done), 1);
        chk(cycle_cnt == 16'(3 + lat_acc), req, "total cycles", int'(cycle_cnt), 3 + lat_acc);
        frozen = int'(cycle_cnt);
        repeat (3) @(negedge clk);
        chk(done && (int'(cycle_cnt) == frozen), "R9", "counter frozen", int'(cycle_cnt), frozen);
        chk(sbq.size() == 0, "R7", "pending stores", sbq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
        chk(cycle_cnt == 16'd0, "R10", "counter after reset", int'(cycle_cnt), 0);
        chk(st_we == 1'b0, "R10", "store strobe after reset", int'(st_we), 0);

        // R1 single one-cycle instruction completes in cycle 4
        wr_pre(1'b1, 0, 16'd5);
        new_prog();
        put_op(3'd0, 3'd1, 3'd0, 3'd0);
        run_prog("R1", 1'b0);

        // R4 dependent chain finishes in cycle 12: (100 - 5*(3+4)) / 7 = 9
        wr_pre(1'b1, 0, 16'd3);
        wr_pre(1'b1, 1, 16'd4);
        wr_pre(1'b1, 2, 16'd5);
        wr_pre(1'b1, 3, 16'd100);
        wr_pre(1'b1, 4, 16'd7);
        new_prog();
        put_op(3'd0, 3'd5, 3'd0, 3'd1);
        put_op(3'd2, 3'd6, 3'd2, 3'd5);
        put_op(3'd1, 3'd5, 3'd3, 3'd6);
        put_op(3'd3, 3'd6, 3'd5, 3'd4);
        put_st(3'd6, 7'h21, 16'd9);
        run_prog("R4", 1'b0);
        chk(cycle_cnt == 16'd12, "R4", "chain cycle count", int'(cycle_cnt), 12);

        // R6 multiply overflow, divide by zero, subtract wrap; R2 latency sum
        wr_pre(1'b1, 0, 16'd300);
        wr_pre(1'b1, 3, 16'd0);
        new_prog();
        put_op(3'd2, 3'd1, 3'd0, 3'd0);
        put_op(3'd3, 3'd2, 3'd1, 3'd3);
        put_st(3'd1, 7'h10, 16'h5F90);
        put_st(3'd2, 7'h11, 16'hFFFF);
        put_op(3'd1, 3'd4, 3'd3, 3'd0);
        put_st(3'd4, 7'h12, 16'hFED4);
        run_prog("R2", 1'b0);

        // R5 writeback bypass: third add reads a register in writeback
        wr_pre(1'b1, 0, 16'd5);
        new_prog();
        put_op(3'd0, 3'd1, 3'd0, 3'd0);
        put_op(3'd0, 3'd2, 3'd0, 3'd0);
        put_op(3'd0, 3'd3, 3'd1, 3'd1);
        put_st(3'd3, 7'h05, 16'd20);
        put_st(3'd1, 7'h06, 16'd10);
        run_prog("R5", 1'b0);

        // R8 opcodes 5..7 write nothing and take one cycle
        wr_pre(1'b1, 7, 16'h1234);
        new_prog();
        put_op(3'd5, 3'd7, 3'd0, 3'd0);
        put_op(3'd6, 3'd7, 3'd0, 3'd0);
        put_op(3'd7, 3'd7, 3'd0, 3'd0);
        put_st(3'd7, 7'h07, 16'h1234);
        run_prog("R8", 1'b0);

        // R11 preload during a run is ignored (register 7 keeps 0x1234)
        wr_pre(1'b1, 0, 16'd2);
        new_prog();
        put_op(3'd2, 3'd1, 3'd0, 3'd0);
        put_op(3'd2, 3'd2, 3'd1, 3'd1);
        put_st(3'd2, 7'h08, 16'd16);
        put_st(3'd7, 7'h09, 16'h1234);
        run_prog("R11", 1'b1);

        // R3 independent short ops wait behind a long divide
        wr_pre(1'b1, 0, 16'd50);
        wr_pre(1'b1, 1, 16'd5);
        new_prog();
        put_op(3'd3, 3'd2, 3'd0, 3'd1);
        put_op(3'd0, 3'd3, 3'd0, 3'd1);
        put_op(3'd1, 3'd4, 3'd0, 3'd1);
        put_st(3'd3, 7'h0A, 16'd55);
        put_st(3'd4, 7'h0B, 16'd45);
        put_st(3'd2, 7'h0C, 16'd10);
        run_prog("R3", 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule